// File: doc/BRIEF.md
# Word-Serial Filter Coefficient Loader

This block is the loading port of one channel of a two-channel FIR image filter. Coefficients and control values arrive over one 12-bit bus, one word per clock. The first word of a burst is an address. Its upper three bits pick a class of target storage, and its lower nine bits pick an entry inside that class. The data words that follow are gathered in a holding buffer. The target storage is written once, through a single-cycle strobe, when the last word of the burst has been captured. Target storage is never written with a partly gathered burst.

The burst length depends on the target class. A coefficient set takes eight data words. A round or limit register takes four. A configuration or select register takes one. After the last data word of a burst, the next bus word is an address again, so bursts can follow one another with no gap. An active-low load enable frames a loading session. Two copies of the block serve filter A and filter B. Each copy may write only its own coefficient banks, and either copy may write the shared configuration space. The parameter `PORT_ID` tells each copy which filter it serves.

Top module: `coef_load_port`

## Requirements
- R1: While reset is asserted, and after it is released, `wr_valid` is 0 and `wr_target`, `wr_index` and `wr_data` are all zero.
- R2: The first word sampled with `load_n` low, and the first word sampled after any completed burst, is an address. Its bits 11..9 appear on `wr_target` and its bits 8..0 appear on `wr_index` during that burst's strobe.
- R3: Target class 0 (coefficient set) takes eight data words. `wr_valid` rises only after the clock edge that captures the eighth word, and the k-th data word (k = 0..7) appears at `wr_data[12k+11:12k]`.
- R4: Target classes 4 to 7 (round registers and limit registers of filter A or B) take four data words. At their strobe, `wr_data` bits 95..48 are zero.
- R5: Target classes 1, 2 and 3 (configuration registers, filter A select registers, filter B select registers) take one data word. The strobe follows the edge that captures that word, with the word in `wr_data[11:0]`.
- R6: `wr_valid` lasts exactly one cycle per burst. A word presented in the cycle after the last data word is taken as a new address, with no idle cycle needed.
- R7: For class 0, address bit 8 names the filter (0 = A, 1 = B). If that bit differs from `PORT_ID`, all eight data words are still consumed, but no strobe is issued.
- R8: A clock edge that samples `load_n` high returns the port to the address phase and produces no strobe. A burst cut short this way is discarded. Raising `load_n` in the cycle after the final data word still leaves that burst's strobe in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Loading session enable, active low |
| bus_in | input | 12 | Shared address / data word |
| wr_valid | output | 1 | Single-cycle write strobe for a completed burst |
| wr_target | output | 3 | Target class taken from address bits 11..9 |
| wr_index | output | 9 | Entry index taken from address bits 8..0 |
| wr_data | output | 96 | Gathered burst; the first data word is in the lowest 12 bits |

## Verification
Two events can fall in the same cycle.

- **Strobe and next address.** The write strobe of a finished burst is high in the same cycle that the bus already carries the next address. The bench chains bursts of every length with no idle cycle between them. It checks that each strobe carries its own burst's target, index and data, and that the following address is not swallowed as data.
- **Load enable and final word.** The rise of `load_n` can land on the very edge that would capture a burst's final word, or one cycle later. The bench drives both timings. It expects a discarded burst in the first case and a normal strobe in the second.

// File: rtl/coef_load_pkg.sv
package coef_load_pkg;

    typedef enum logic [2:0] {
        TGT_COEF  = 3'd0,
        TGT_CFG   = 3'd1,
        TGT_SEL_A = 3'd2,
        TGT_SEL_B = 3'd3,
        TGT_RND_A = 3'd4,
        TGT_RND_B = 3'd5,
        TGT_LIM_A = 3'd6,
        TGT_LIM_B = 3'd7
    } tgt_e;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/load_decode.sv
module load_decode
    import coef_load_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int COEF_WORDS = 8,
    parameter int RL_WORDS   = 4,
    parameter int CFG_WORDS  = 1,
    parameter int PORT_ID    = 0
) (
    input  tgt_e             cls,
    input  logic             bank_sel,
    output logic [CNT_W-1:0] last_idx,
    output logic             permit
);

    // Index of the final data word for each target class
    always_comb begin
        unique case (cls)
            TGT_COEF:                      last_idx = CNT_W'(COEF_WORDS - 1);
            TGT_CFG, TGT_SEL_A, TGT_SEL_B: last_idx = CNT_W'(CFG_WORDS - 1);
            default:                       last_idx = CNT_W'(RL_WORDS - 1);
        endcase
    end

    // Coefficient banks belong to one filter; everything else is shared
    always_comb begin
        permit = (cls != TGT_COEF) || (bank_sel == PORT_ID[0]);
    end

endmodule

// File: rtl/load_buffer.sv
module load_buffer #(
    parameter int WORD_W = 12,
    parameter int SLOTS  = 8,
    parameter int IDX_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [WORD_W-1:0]         wr_word,
    output logic [SLOTS*WORD_W-1:0]   data
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr) begin
                slot_d = '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d = wr_word;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign data[g*WORD_W +: WORD_W] = slot_q;
    end

endmodule

// File: rtl/coef_load_port.sv
module coef_load_port
    import coef_load_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter int COEF_WORDS = 8,
    parameter int RL_WORDS   = 4,
    parameter int CFG_WORDS  = 1,
    parameter int PORT_ID    = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_n,
    input  logic [WORD_W-1:0]              bus_in,
    output logic                           wr_valid,
    output logic [2:0]                     wr_target,
    output logic [WORD_W-4:0]              wr_index,
    output logic [COEF_WORDS*WORD_W-1:0]   wr_data
);

    localparam int TGT_W  = 3;
    localparam int ADDR_W = WORD_W - TGT_W;
    localparam int DATA_W = COEF_WORDS * WORD_W;
    localparam int CNT_W  = (COEF_WORDS > 1) ? $clog2(COEF_WORDS) : 1;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        tgt_e               cls;
        logic [ADDR_W-1:0]  addr;
        logic               permit;
        logic               strobe;
    } st_t;

    st_t st_d, st_q;

    tgt_e             dec_cls;
    logic             dec_bank;
    logic [CNT_W-1:0] dec_last;
    logic             dec_permit;

    logic             buf_clr;
    logic             buf_we;
    logic [DATA_W-1:0] buf_data;

    // Address phase decodes the live bus; data phase decodes the held address
    always_comb begin
        if (st_q.phase == PH_ADDR) begin
            dec_cls  = tgt_e'(bus_in[WORD_W-1 -: TGT_W]);
            dec_bank = bus_in[ADDR_W-1];
        end else begin
            dec_cls  = st_q.cls;
            dec_bank = st_q.addr[ADDR_W-1];
        end
    end

    load_decode #(
        .CNT_W      (CNT_W),
        .COEF_WORDS (COEF_WORDS),
        .RL_WORDS   (RL_WORDS),
        .CFG_WORDS  (CFG_WORDS),
        .PORT_ID    (PORT_ID)
    ) u_dec (
        .cls      (dec_cls),
        .bank_sel (dec_bank),
        .last_idx (dec_last),
        .permit   (dec_permit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        buf_clr     = 1'b0;
        buf_we      = 1'b0;
        if (load_n) begin
            st_d.phase = PH_ADDR;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_ADDR) begin
            st_d.cls    = tgt_e'(bus_in[WORD_W-1 -: TGT_W]);
            st_d.addr   = bus_in[ADDR_W-1:0];
            st_d.permit = dec_permit;
            st_d.phase  = PH_DATA;
            st_d.cnt    = '0;
            buf_clr     = 1'b1;
        end else begin
            buf_we = 1'b1;
            if (st_q.cnt == dec_last) begin
                st_d.strobe = st_q.permit;
                st_d.phase  = PH_ADDR;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_ADDR, cnt: '0, cls: TGT_COEF, addr: '0,
                      permit: 1'b0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    load_buffer #(
        .WORD_W (WORD_W),
        .SLOTS  (COEF_WORDS),
        .IDX_W  (CNT_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_we),
        .wr_idx  (st_q.cnt),
        .wr_word (bus_in),
        .data    (buf_data)
    );

    assign wr_valid  = st_q.strobe;
    assign wr_target = st_q.cls;
    assign wr_index  = st_q.addr;
    assign wr_data   = buf_data;

endmodule

// File: rtl/coef_load_port_chk.sv
module coef_load_port_chk #(
    parameter int WORD_W   = 12,
    parameter int DATA_W   = 96,
    parameter int RL_WORDS = 4,
    parameter int PORT_ID  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n,
    input logic              wr_valid,
    input logic [2:0]        wr_target,
    input logic [WORD_W-4:0] wr_index,
    input logic [DATA_W-1:0] wr_data
);

    // R8: an edge that samples load_n high never yields a strobe
    assert_idle_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> !wr_valid);

    // R6: the strobe is a single-cycle pulse
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R7: a coefficient strobe only ever targets this port's own filter
    assert_own_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_target == 3'd0) |-> (wr_index[WORD_W-4] == PORT_ID[0]));

    // R4: round/limit bursts leave the unused upper words clear
    assert_short_burst_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_target[2]) |-> (wr_data[DATA_W-1:RL_WORDS*WORD_W] == '0));

endmodule

bind coef_load_port coef_load_port_chk #(
    .WORD_W   (WORD_W),
    .DATA_W   (DATA_W),
    .RL_WORDS (RL_WORDS),
    .PORT_ID  (PORT_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .wr_valid  (wr_valid),
    .wr_target (wr_target),
    .wr_index  (wr_index),
    .wr_data   (wr_data)
);

// File: tb/coef_load_port_test.sv
`timescale 1ns/1ps
module coef_load_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_n = 1'b1;
    logic [11:0] bus_in = '0;
    logic        wr_valid;
    logic [2:0]  wr_target;
    logic [8:0]  wr_index;
    logic [95:0] wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    coef_load_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .bus_in    (bus_in),
        .wr_valid  (wr_valid),
        .wr_target (wr_target),
        .wr_index  (wr_index),
        .wr_data   (wr_data)
    );

    typedef struct packed {
        logic        ld_n;
        logic [11:0] word;
        logic        ev;
        logic [2:0]  ec;
        logic [8:0]  ea;
        logic [11:0] ew;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h212, 1'b0, 3'd0, 9'h000, 12'h000}, // cfg addr (R2)
        '{1'b0, 12'hABC, 1'b1, 3'd1, 9'h012, 12'hABC}, // R5
        '{1'b0, 12'h405, 1'b0, 3'd0, 9'h000, 12'h000}, // back-to-back addr (R6)
        '{1'b0, 12'h111, 1'b1, 3'd2, 9'h005, 12'h111}, // R5 select A
        '{1'b0, 12'h6AA, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h5A5, 1'b1, 3'd3, 9'h0AA, 12'h5A5}, // R5 select B
        '{1'b0, 12'h803, 1'b0, 3'd0, 9'h000, 12'h000}, // round A
        '{1'b0, 12'h001, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h002, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h003, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h004, 1'b1, 3'd4, 9'h003, 12'h001}, // R4
        '{1'b0, 12'hFFF, 1'b0, 3'd0, 9'h000, 12'h000}, // limit B
        '{1'b0, 12'h010, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h020, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h030, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b1, 12'h040, 1'b0, 3'd0, 9'h000, 12'h000}, // abort (R8)
        '{1'b0, 12'h040, 1'b0, 3'd0, 9'h000, 12'h000}, // coef addr (R2)
        '{1'b0, 12'h100, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h101, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h102, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h103, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h104, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h105, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h106, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b0, 12'h107, 1'b1, 3'd0, 9'h040, 12'h100}, // R3
        '{1'b1, 12'h000, 1'b0, 3'd0, 9'h000, 12'h000}, // R8 session end
        '{1'b0, 12'hC07, 1'b0, 3'd0, 9'h000, 12'h000}, // limit A
        '{1'b0, 12'h00A, 1'b0, 3'd0, 9'h000, 12'h000},
        '{1'b1, 12'h00B, 1'b0, 3'd0, 9'h000, 12'h000}, // abort mid-burst (R8)
        '{1'b0, 12'h00C, 1'b0, 3'd0, 9'h000, 12'h000}, // new addr: cls0 idx 0x00C
        '{1'b1, 12'h00D, 1'b0, 3'd0, 9'h000, 12'h000}, // abort again
        '{1'b1, 12'h000, 1'b0, 3'd0, 9'h000, 12'h000}
    };

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic ld, input logic [11:0] w);
        load_n = ld;
        bus_in = w;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid", 96'(wr_valid), 96'd0);
        check("R1 target", 96'(wr_target), 96'd0);
        check("R1 index", 96'(wr_index), 96'd0);
        check("R1 data", wr_data, 96'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 96'(wr_valid), 96'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].ld_n, VECS[i].word);
            check("R2/R3/R4/R5/R8 table valid", 96'(wr_valid), 96'(VECS[i].ev));
            if (VECS[i].ev) begin
                check("R2 table target", 96'(wr_target), 96'(VECS[i].ec));
                check("R2 table index", 96'(wr_index), 96'(VECS[i].ea));
                check("R3 table word0", 96'(wr_data[11:0]), 96'(VECS[i].ew));
            end
        end

        // R3: full coefficient burst with data layout, strobe only after eighth word
        step(0, 12'h0A5);
        for (int k = 0; k < 8; k++) begin
            step(0, 12'h300 + 12'(k));
            check("R3 strobe timing", 96'(wr_valid), (k == 7) ? 96'd1 : 96'd0);
        end
        check("R3 data layout", wr_data,
              {12'h307, 12'h306, 12'h305, 12'h304, 12'h303, 12'h302, 12'h301, 12'h300});
        check("R2 coef index", 96'(wr_index), 96'h0A5);

        // R6: next word right after the burst is an address (round B)
        step(0, 12'hBEE);
        check("R6 single pulse", 96'(wr_valid), 96'd0);
        step(0, 12'h00E); step(0, 12'h00F); step(0, 12'h010); step(0, 12'h011);
        check("R4 strobe", 96'(wr_valid), 96'd1);
        check("R4 target", 96'(wr_target), 96'd5);
        check("R4 data upper clear", wr_data,
              {48'd0, 12'h011, 12'h010, 12'h00F, 12'h00E});

        // R7: coefficient bank of filter B on port A is consumed without strobe
        step(0, 12'h1C3);
        for (int k = 0; k < 8; k++) begin
            step(0, 12'h700 + 12'(k));
            check("R7 no strobe", 96'(wr_valid), 96'd0);
        end
        step(0, 12'h233);
        check("R7 burst consumed", 96'(wr_valid), 96'd0);
        step(0, 12'h777);
        check("R7 following cfg strobe", 96'(wr_valid), 96'd1);
        check("R7 following cfg index", 96'(wr_index), 96'h033);

        // R8: load_n rising on the edge that would capture the final word
        step(0, 12'h244);
        step(1, 12'h555);
        check("R8 abort at final word", 96'(wr_valid), 96'd0);
        step(1, 12'h000);
        check("R8 idle", 96'(wr_valid), 96'd0);

        // R8: load_n rising the cycle after the final word keeps the strobe
        step(0, 12'h255);
        step(0, 12'h666);
        check("R8 strobe before session end", 96'(wr_valid), 96'd1);
        step(1, 12'h000);
        check("R8 session end", 96'(wr_valid), 96'd0);

        finish_run();
    end

endmodule